// File: doc/BRIEF.md
# Link Controller Interrupt Status and Mask Unit

This block collects single-cycle event pulses from a storage link controller (the ATA device interrupt, the link error indication, error and critical-error events and the remaining sources) into a sticky status register. A per-bit mask register decides which latched events may raise the single interrupt line. That line is further gated by one global enable bit that sits in a separate enable register. Software reads the three registers through a small word-wide register port. It clears status by writing zeros: each bit written as 0 is cleared and each bit written as 1 is left as it is.

The number of event sources is a parameter with two legal values, 11 or 12. Register bits above the last source read as zero. After reset every source is masked, no status is pending and the global enable is off.

Top module: `link_irq_agg`

## Requirements
- R1: After reset the status register reads 0, the mask register reads all ones for the configured width (0xFFF with 12 sources, 0x7FF with 11), the enable register reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets status bit k at the next clock edge. The bit stays set after the pulse ends and can be read at register address 0. The link-error event is bit 3 and the ATA device event is bit 0.
- R3: A write to address 0 clears every status bit written as 0 and leaves every status bit written as 1 unchanged.
- R4: When an event arrives in the same cycle as a write that would clear its status bit, the bit is set after that edge.
- R5: A mask bit at 1 (address 1) keeps its status bit from raising `irq_o`. The status bit is still recorded. Mask bit 3 belongs to the link error, bit 2 to the error event, bit 1 to the critical error and bit 0 to the ATA event.
- R6: The enable register (address 2) stores only bit 11, the global enable. `irq_o` stays low while that bit is 0, even when the other bits of the register are written as 1. All other bits of the register read as 0.
- R7: `irq_o` is high exactly when the global enable is set and at least one status bit is set with its mask bit clear. It follows the register state in the same cycle, so it rises one edge after the event pulse.
- R8: With 11 sources, bit 11 and above read as 0 in the status and mask registers, even after all ones are written.
- R9: Register address 3 reads as 0.
- R10: Writing all zeros to address 0 clears every status bit that has no event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
Status, mask and enable are each written at a clock edge. A write or event driven in one cycle is therefore visible one edge later: in the register read data, which is a combinational mux of the registers, and in `irq_o`, which is combinational from those same registers. The bench drives each vector on the falling edge. It lets the rising edge capture the vector, then one step later returns the port to an idle read of the status register and samples both results, before the next edge. Reads in the directed tests follow the same rule: the address is set away from the edge and the data is sampled before the next edge.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

  localparam int REG_ADDR_W = 2;
  localparam int REG_DATA_W = 32;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // source positions that software decodes
  localparam int SRC_ATA      = 0;
  localparam int SRC_CRIT     = 1;
  localparam int SRC_ERR      = 2;
  localparam int SRC_LINKERR  = 3;
  localparam int GLOBAL_EN_POS = 11;

  // all-ones value for an n-bit field inside a data word
  function automatic logic [REG_DATA_W-1:0] ones_of(input int n);
    logic [REG_DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_DATA_W; i++) begin
      if (i < n) v[i] = 1'b1;
    end
    return v;
  endfunction

  // next value of one status bit
  function automatic logic stat_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // interrupt condition
  function automatic logic irq_cond(input logic en, input logic any_open);
    return en & any_open;
  endfunction

endpackage

// File: rtl/irqa_stat_cell.sv
module irqa_stat_cell
  import irqa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_req,
  input  logic set_req,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= stat_next(q, clr_req, set_req);
  end
endmodule

// File: rtl/irqa_stat_bank.sv
module irqa_stat_bank #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stat,
  input  logic [NUM_SRC-1:0] wr_bits,
  input  logic [NUM_SRC-1:0] evt,
  output logic [NUM_SRC-1:0] stat
);
  logic [NUM_SRC-1:0] clr_vec;

  // a bit written as zero requests a clear
  assign clr_vec = {NUM_SRC{wr_stat}} & ~wr_bits;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cell
    irqa_stat_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_req (clr_vec[k]),
      .set_req (evt[k]),
      .q       (stat[k])
    );
  end
endmodule

// File: rtl/irqa_cfg_regs.sv
module irqa_cfg_regs #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] mask_bits,
  input  logic               en_bit,
  output logic [NUM_SRC-1:0] mask,
  output logic               en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
      en   <= 1'b0;
    end else begin
      if (wr_mask) mask <= mask_bits;
      if (wr_en)   en   <= en_bit;
    end
  end
endmodule

// File: rtl/irqa_out_gate.sv
module irqa_out_gate
  import irqa_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic [NUM_SRC-1:0] stat,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               en,
  output logic [NUM_SRC-1:0] open_vec,
  output logic               irq
);
  assign open_vec = stat & ~mask;
  assign irq      = irq_cond(en, |open_vec);
endmodule

// File: rtl/link_irq_agg.sv
module link_irq_agg
  import irqa_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    evt_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [REG_DATA_W-1:0] reg_wdata_i,
  output logic [REG_DATA_W-1:0] reg_rdata_o,
  output logic                  irq_o
);
  localparam logic [REG_DATA_W-1:0] SRC_FIELD = ones_of(NUM_SRC);

  reg_sel_e           sel;
  logic               stat_wr;
  logic               mask_wr;
  logic               en_wr;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               en_q;
  logic [NUM_SRC-1:0] open_vec;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign stat_wr = reg_we_i && (sel == SEL_STATUS);
  assign mask_wr = reg_we_i && (sel == SEL_MASK);
  assign en_wr   = reg_we_i && (sel == SEL_ENABLE);

  irqa_stat_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stat (stat_wr),
    .wr_bits (reg_wdata_i[NUM_SRC-1:0]),
    .evt     (evt_i),
    .stat    (stat_q)
  );

  irqa_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask   (mask_wr),
    .wr_en     (en_wr),
    .mask_bits (reg_wdata_i[NUM_SRC-1:0]),
    .en_bit    (reg_wdata_i[GLOBAL_EN_POS]),
    .mask      (mask_q),
    .en        (en_q)
  );

  irqa_out_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .stat     (stat_q),
    .mask     (mask_q),
    .en       (en_q),
    .open_vec (open_vec),
    .irq      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata_o[NUM_SRC-1:0] = stat_q;
      SEL_MASK:   reg_rdata_o[NUM_SRC-1:0] = mask_q;
      SEL_ENABLE: reg_rdata_o[GLOBAL_EN_POS] = en_q;
      default:    reg_rdata_o = '0;
    endcase
    reg_rdata_o = reg_rdata_o & (SRC_FIELD | (REG_DATA_W'(1) << GLOBAL_EN_POS));
  end

endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
  parameter int NUM_SRC = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt,
  input logic               stat_wr,
  input logic [NUM_SRC-1:0] wbits,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               en_q,
  input logic               irq,
  input logic [31:0]        rdata
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2 / R4: a pulsed source is set after the edge
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R3: without a status write nothing is lost
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !stat_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R10: zero-written bits without an event are cleared
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && stat_wr) |=> ((stat_q & ~$past(evt) & ~$past(wbits)) == '0));

  // R6: no interrupt without the global enable
  p_need_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q);

  // R5 / R7: interrupt only with an unmasked pending source
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_q & ~mask_q) != '0));

  // R8: bits above bit 11 never read as 1
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> 12) == 32'd0);
endmodule

bind link_irq_agg irqa_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt_i),
  .stat_wr (stat_wr),
  .wbits   (reg_wdata_i[NUM_SRC-1:0]),
  .stat_q  (stat_q),
  .mask_q  (mask_q),
  .en_q    (en_q),
  .irq     (irq_o),
  .rdata   (reg_rdata_o)
);

// File: tb/link_irq_agg_test.sv
`timescale 1ns/1ps
module link_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  logic [10:0] evt11 = '0;
  logic        we11 = 1'b0;
  logic [1:0]  addr11 = 2'd0;
  logic [31:0] wdata11 = '0;
  logic [31:0] rdata11;
  logic        irq11;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  link_irq_agg #(.NUM_SRC(12)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  link_irq_agg #(.NUM_SRC(11)) uut11 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt11), .reg_we_i(we11), .reg_addr_i(addr11),
    .reg_wdata_i(wdata11), .reg_rdata_o(rdata11), .irq_o(irq11));

  // vector table: write enable, address, write data, event, expected status, expected irq
  localparam int NV = 13;
  localparam logic        V_WE [NV] = '{1,0,1,0,1,0,1,1,1,1,1,1,1};
  localparam logic [1:0]  V_AD [NV] = '{1,0,2,0,0,0,0,0,1,2,1,2,0};
  localparam logic [11:0] V_WD [NV] = '{12'hFF6,12'h000,12'h800,12'h000,12'hFFE,12'h000,
                                        12'hFFF,12'h000,12'hFFF,12'h7FF,12'hFF7,12'h800,12'h000};
  localparam logic [11:0] V_EV [NV] = '{12'h000,12'h001,12'h000,12'h020,12'h000,12'h008,
                                        12'h000,12'h008,12'h000,12'h000,12'h000,12'h000,12'h000};
  localparam logic [11:0] V_ST [NV] = '{12'h000,12'h001,12'h001,12'h021,12'h020,12'h028,
                                        12'h028,12'h008,12'h008,12'h008,12'h008,12'h008,12'h000};
  localparam logic        V_IQ [NV] = '{0,0,1,1,0,1,1,1,0,0,0,1,0};
  // requirement each vector targets: R5 unmask, R2 ATA event, R7 enable, R5 masked
  // event, R3 clear bit 0, R2 link error, R3 ones keep, R4 event beats clear,
  // R5 mask all, R6 other enable bits, R5 unmask bit 3, R7 enable, R10 clear all
  localparam int V_RQ [NV] = '{5,2,7,5,3,2,3,4,5,6,5,7,10};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // register write on the 12-source unit, driven away from the edge
  task automatic wr12(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd12(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr11(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we11 = 1'b1; addr11 = a; wdata11 = d;
    @(negedge clk);
    we11 = 1'b0;
  endtask

  task automatic rd11(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr11 = a;
    #1 d = rdata11;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd12(2'd0, d); check("R1 status", d, 32'h0);
    rd12(2'd1, d); check("R1 mask", d, 32'hFFF);
    rd12(2'd2, d); check("R1 enable", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd11(2'd1, d); check("R1 mask 11", d, 32'h7FF);

    // vector loop
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = V_WE[i]; addr = V_AD[i]; wdata = {20'd0, V_WD[i]}; evt = V_EV[i];
      @(posedge clk);
      #1;
      we = 1'b0; evt = '0; addr = 2'd0;
      #1;
      check($sformatf("R%0d vector %0d status", V_RQ[i], i), rdata, {20'd0, V_ST[i]});
      check($sformatf("R%0d vector %0d irq", V_RQ[i], i), {31'd0, irq}, {31'd0, V_IQ[i]});
    end

    // R6: only the global enable bit is stored
    wr12(2'd2, 32'hFFFF_FFFF);
    rd12(2'd2, d); check("R6 enable readback", d, 32'h800);
    wr12(2'd2, 32'h0);

    // R9: unused address reads zero
    rd12(2'd3, d); check("R9 address 3", d, 32'h0);

    // R8: 11-source variant drops bit 11
    wr11(2'd1, 32'hFFFF_FFFF);
    rd11(2'd1, d); check("R8 mask 11", d, 32'h7FF);
    @(negedge clk); evt11 = 11'h400;
    @(negedge clk); evt11 = '0;
    rd11(2'd0, d); check("R8 status 11 top source", d, 32'h400);
    wr11(2'd0, 32'hFFFF_FFFF);
    rd11(2'd0, d); check("R8 status 11 after ones", d, 32'h400);

    // R2: sticky after pulse, several cycles later
    @(negedge clk); evt = 12'h804;
    @(negedge clk); evt = '0;
    repeat (3) @(negedge clk);
    rd12(2'd0, d); check("R2 sticky", d, 32'h804);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd12(2'd0, d); check("R1 status after reset", d, 32'h0);
    rd12(2'd1, d); check("R1 mask after reset", d, 32'hFFF);

    finish_run();
  end
endmodule